// File: doc/BRIEF.md
# Flow expiry scanner

This block retires stale entries from a hashed flow table. It owns the second port of the dual-port table RAM and runs alongside the packet update engine on the first port, with no coordination between the two. It walks the table addresses in ascending order, one entry at a time, and reads each record. When a record is marked busy and has aged past either of two programmable limits, the block hands the record to an export stream. Once the record is accepted, the block writes the record back with its busy bit cleared, which frees the slot for a new flow.

Two ages are measured against a free-running timestamp input. The first is idle time, which runs from the last packet's stamp. The second is total lifetime, which runs from the creation stamp. Both differences use wrap-around arithmetic, so the timestamp counter may roll over freely. When the export sink stalls, the sweep stalls with it. The entry being exported is not cleared until the sink has taken it.

Record layout, from the most significant bit down: busy (1 bit), flow key (KEY_W), creation stamp (TS_W), last-packet stamp (TS_W), counters (CNT_W). The table RAM has a one-cycle synchronous read.

Top module: `flow_sweeper`

## Requirements
- R1: While reset is held, and in the cycle after it is released, no record is offered (exp_valid low) and no write is issued (tbl_we low). The first read goes to address 0.
- R2: Successive reads go to successive addresses 0, 1, …, DEPTH-1, and the address then wraps to 0, so every entry is visited once per sweep.
- R3: An entry whose busy bit (bit REC_W-1) is 0 produces no export and no write.
- R4: A busy entry is expired when (now_ts − last stamp) mod 2^TS_W ≥ idle_limit. The last stamp occupies bits [CNT_W+TS_W-1 : CNT_W].
- R5: A busy entry is expired when (now_ts − creation stamp) mod 2^TS_W ≥ life_limit. The creation stamp occupies bits [CNT_W+2·TS_W-1 : CNT_W+TS_W].
- R6: Either condition alone causes expiry. A busy entry that meets neither condition is neither exported nor rewritten.
- R7: An expired record is presented on exp_rec exactly as stored, with the busy bit still 1, while exp_valid is high.
- R8: After the export is accepted, the entry is written back at the same address with the busy bit 0 and every other bit unchanged.
- R9: While exp_valid is high and exp_ready is low, the following all hold: exp_rec and tbl_addr do not change, no read is issued, and no write is issued.
- R10: Expiry is decided correctly when the timestamp counter has rolled over between the stored stamp and now_ts.
- R11: Each expired entry is exported exactly once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| now_ts | input | TS_W | Free-running current timestamp |
| idle_limit | input | TS_W | Inactivity timeout |
| life_limit | input | TS_W | Maximum flow duration |
| tbl_addr | output | log2(DEPTH) | Table address for read and write |
| tbl_rd | output | 1 | Read strobe; data returns next cycle |
| tbl_rdata | input | REC_W | Read data from table |
| tbl_we | output | 1 | Write strobe |
| tbl_wdata | output | REC_W | Write data (record with busy cleared) |
| exp_valid | output | 1 | Exported record valid |
| exp_ready | input | 1 | Export sink ready |
| exp_rec | output | REC_W | Exported record |

## Verification
The hardest situation to reach is a stalled export. In that state the sweep must freeze and the table entry must stay busy until the very cycle after acceptance. The bench holds exp_ready low before it plants an idle-expired entry. It then watches the address, the read strobe, the record and its own RAM model over many stalled cycles before it releases the sink. The exact boundaries of both age limits are reached by placing one entry whose age exactly equals the limit next to one entry that is a single tick short. The rollover case is reached the same way, using a stamp just below the counter's maximum and a small current time.

// File: rtl/flow_sweep_pkg.sv
package flow_sweep_pkg;
  typedef enum logic [1:0] {
    SW_READ  = 2'd0,
    SW_EVAL  = 2'd1,
    SW_HOLD  = 2'd2,
    SW_CLEAR = 2'd3
  } sweep_state_t;
endpackage

// File: rtl/flow_age_cmp.sv
// Wrap-safe age comparison: modular distance from stamp to now against a limit.
module flow_age_cmp #(
  parameter int TS_W = 16
) (
  input  logic [TS_W-1:0] now,
  input  logic [TS_W-1:0] stamp,
  input  logic [TS_W-1:0] limit,
  output logic            reached
);
  logic [TS_W-1:0] age;
  assign age     = now - stamp;
  assign reached = (age >= limit);
endmodule

// File: rtl/flow_sweep_idx.sv
// Scan pointer: advances on step, wraps from DEPTH-1 to 0.
module flow_sweep_idx #(
  parameter int DEPTH = 16,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  output logic [AW-1:0] idx
);
  localparam logic [AW-1:0] LAST = AW'(DEPTH - 1);

  always_ff @(posedge clk) begin
    if (rst)       idx <= '0;
    else if (step) idx <= (idx == LAST) ? '0 : idx + 1'b1;
  end

  p_wrap_r2: assert property (@(posedge clk) disable iff (rst)
    (step && idx == LAST) |=> (idx == '0));
  p_hold_idx_r2: assert property (@(posedge clk) disable iff (rst)
    !step |=> $stable(idx));
endmodule

// File: rtl/flow_sweeper.sv
module flow_sweeper
  import flow_sweep_pkg::*;
#(
  parameter int DEPTH = 16,
  parameter int KEY_W = 16,
  parameter int TS_W  = 16,
  parameter int CNT_W = 16,
  localparam int AW       = $clog2(DEPTH),
  localparam int REC_W    = 1 + KEY_W + 2*TS_W + CNT_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [TS_W-1:0]  now_ts,
  input  logic [TS_W-1:0]  idle_limit,
  input  logic [TS_W-1:0]  life_limit,
  output logic [AW-1:0]    tbl_addr,
  output logic             tbl_rd,
  input  logic [REC_W-1:0] tbl_rdata,
  output logic             tbl_we,
  output logic [REC_W-1:0] tbl_wdata,
  output logic             exp_valid,
  input  logic             exp_ready,
  output logic [REC_W-1:0] exp_rec
);
  localparam int BUSY_BIT = REC_W - 1;
  localparam int LAST_LO  = CNT_W;
  localparam int FIRST_LO = CNT_W + TS_W;
  localparam int N_AGE    = 2;

  sweep_state_t    state;
  logic [REC_W-1:0] hold_rec, wdata_q;
  logic            valid_q, we_q;
  logic            step, expire;
  logic [AW-1:0]   idx;

  // Age conditions: index 0 = inactivity, index 1 = lifetime
  logic [TS_W-1:0] stamp_sel [N_AGE];
  logic [TS_W-1:0] limit_sel [N_AGE];
  logic [N_AGE-1:0] hit;

  assign stamp_sel[0] = tbl_rdata[LAST_LO  +: TS_W];
  assign limit_sel[0] = idle_limit;
  assign stamp_sel[1] = tbl_rdata[FIRST_LO +: TS_W];
  assign limit_sel[1] = life_limit;

  for (genvar g = 0; g < N_AGE; g++) begin : g_age
    flow_age_cmp #(.TS_W(TS_W)) u_cmp (
      .now     (now_ts),
      .stamp   (stamp_sel[g]),
      .limit   (limit_sel[g]),
      .reached (hit[g])
    );
  end

  assign expire = tbl_rdata[BUSY_BIT] && (|hit);
  assign step   = ((state == SW_EVAL) && !expire) || (state == SW_CLEAR);

  flow_sweep_idx #(.DEPTH(DEPTH), .AW(AW)) u_idx (
    .clk  (clk),
    .rst  (rst),
    .step (step),
    .idx  (idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= SW_READ;
      valid_q  <= 1'b0;
      we_q     <= 1'b0;
      hold_rec <= '0;
      wdata_q  <= '0;
    end else begin
      case (state)
        SW_READ: state <= SW_EVAL;
        SW_EVAL: begin
          if (expire) begin
            hold_rec <= tbl_rdata;
            valid_q  <= 1'b1;
            state    <= SW_HOLD;
          end else begin
            state <= SW_READ;
          end
        end
        SW_HOLD: begin
          if (exp_ready) begin
            valid_q <= 1'b0;
            we_q    <= 1'b1;
            wdata_q <= {1'b0, hold_rec[BUSY_BIT-1:0]};
            state   <= SW_CLEAR;
          end
        end
        SW_CLEAR: begin
          we_q  <= 1'b0;
          state <= SW_READ;
        end
        default: state <= SW_READ;
      endcase
    end
  end

  assign tbl_addr  = idx;
  assign tbl_rd    = (state == SW_READ);
  assign tbl_we    = we_q;
  assign tbl_wdata = wdata_q;
  assign exp_valid = valid_q;
  assign exp_rec   = hold_rec;

  // R9: stalled export freezes everything
  p_stall_r9: assert property (@(posedge clk) disable iff (rst)
    (exp_valid && !exp_ready) |=> (exp_valid && $stable(exp_rec) && $stable(tbl_addr) && !tbl_we && !tbl_rd));
  // R8: a write only follows an accepted export
  p_we_after_accept_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> $past(exp_valid && exp_ready));
  // R8: written record is the exported one with busy dropped
  p_clear_busy_r8: assert property (@(posedge clk) disable iff (rst)
    tbl_we |-> (!tbl_wdata[BUSY_BIT] && tbl_wdata[BUSY_BIT-1:0] == $past(exp_rec[BUSY_BIT-1:0])));
  // R7: only busy records leave the block
  p_export_busy_r7: assert property (@(posedge clk) disable iff (rst)
    exp_valid |-> exp_rec[BUSY_BIT]);
  // R3: a free entry never raises an export
  p_free_silent_r3: assert property (@(posedge clk) disable iff (rst)
    (state == SW_EVAL && !tbl_rdata[BUSY_BIT]) |=> !exp_valid);
endmodule

// File: tb/flow_sweeper_test.sv
`timescale 1ns/1ps
module flow_sweeper_test;
  localparam int DEPTH = 16;
  localparam int KEY_W = 16;
  localparam int TS_W  = 16;
  localparam int CNT_W = 16;
  localparam int AW    = 4;
  localparam int REC_W = 1 + KEY_W + 2*TS_W + CNT_W;
  localparam int KEY_LO = 2*TS_W + CNT_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [TS_W-1:0] now_ts = '0, idle_limit = '0, life_limit = '0;
  logic exp_ready = 1'b1;
  logic [AW-1:0] tbl_addr;
  logic tbl_rd, tbl_we, exp_valid;
  logic [REC_W-1:0] tbl_rdata, tbl_wdata, exp_rec;

  always #2 clk = ~clk;

  flow_sweeper #(.DEPTH(DEPTH), .KEY_W(KEY_W), .TS_W(TS_W), .CNT_W(CNT_W)) uut (
    .clk(clk), .rst(rst), .now_ts(now_ts), .idle_limit(idle_limit), .life_limit(life_limit),
    .tbl_addr(tbl_addr), .tbl_rd(tbl_rd), .tbl_rdata(tbl_rdata), .tbl_we(tbl_we),
    .tbl_wdata(tbl_wdata), .exp_valid(exp_valid), .exp_ready(exp_ready), .exp_rec(exp_rec));

  // Table RAM model with a bench load port
  logic [REC_W-1:0] mem [DEPTH];
  logic             bw_en = 1'b0;
  logic [AW-1:0]    bw_addr = '0;
  logic [REC_W-1:0] bw_data = '0;
  always @(posedge clk) begin
    if (bw_en)       mem[bw_addr]  <= bw_data;
    else if (tbl_we) mem[tbl_addr] <= tbl_wdata;
    if (tbl_rd) tbl_rdata <= mem[tbl_addr];
  end

  logic [REC_W-1:0] golden [DEPTH];
  int hs_cnt [DEPTH];
  int we_cnt = 0, rd_cnt = 0, order_err = 0, rec_err = 0;
  logic [AW-1:0] prev_rd = '0;
  bit have_prev = 0;
  int checks = 0, fails = 0;

  initial for (int i = 0; i < DEPTH; i++) begin hs_cnt[i] = 0; golden[i] = '0; end

  always @(negedge clk) begin
    if (!rst) begin
      if (tbl_rd) begin
        if (have_prev && tbl_addr != prev_rd + 1'b1) order_err++;
        prev_rd = tbl_addr;
        have_prev = 1;
        rd_cnt++;
      end
      if (tbl_we) we_cnt++;
      if (exp_valid && exp_ready) begin
        hs_cnt[exp_rec[KEY_LO +: AW]]++;
        if (exp_rec != golden[exp_rec[KEY_LO +: AW]]) rec_err++;
      end
    end
  end

  function automatic logic [REC_W-1:0] mkrec(input logic busy, input logic [AW-1:0] a,
      input logic [TS_W-1:0] first, input logic [TS_W-1:0] last);
    return {busy, 12'hA00, a, first, last, 16'h1234 ^ {12'h0, a}};
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act, input logic [127:0] expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, expv);
    end
  endtask

  task automatic put(input logic [AW-1:0] a, input logic [REC_W-1:0] r);
    @(posedge clk); #1;
    bw_en = 1'b1; bw_addr = a; bw_data = r; golden[a] = r;
    @(posedge clk); #1;
    bw_en = 1'b0;
  endtask

  task automatic wipe();
    for (int i = 0; i < DEPTH; i++) put(AW'(i), '0);
  endtask

  task automatic set_time(input int t, input int idl, input int lif);
    @(posedge clk); #1;
    now_ts = TS_W'(t); idle_limit = TS_W'(idl); life_limit = TS_W'(lif);
  endtask

  // Runs a sweep window and checks one expected-expired and one expected-kept entry
  task automatic pair_case(input string tag, input logic [AW-1:0] ea, input logic [AW-1:0] ka);
    int base_e, base_k;
    base_e = hs_cnt[ea]; base_k = hs_cnt[ka];
    repeat (120) @(posedge clk);
    @(negedge clk);
    check(hs_cnt[ea] - base_e == 1, {tag, " expired exported once"}, hs_cnt[ea] - base_e, 1);
    check(hs_cnt[ka] - base_k == 0, {tag, " kept entry not exported"}, hs_cnt[ka] - base_k, 0);
    check(mem[ea][REC_W-1] == 1'b0 && mem[ea][REC_W-2:0] == golden[ea][REC_W-2:0],
          {tag, " R8 busy cleared, rest kept"}, mem[ea], {1'b0, golden[ea][REC_W-2:0]});
    check(mem[ka] == golden[ka], {tag, " R6 kept entry untouched"}, mem[ka], golden[ka]);
  endtask

  task automatic t_reset();
    for (int i = 0; i < DEPTH; i++) begin
      @(posedge clk); #1; bw_en = 1'b1; bw_addr = AW'(i); bw_data = '0;
    end
    @(posedge clk); #1; bw_en = 1'b0;
    @(negedge clk);
    check(!exp_valid && !tbl_we && tbl_addr == 0, "R1 reset outputs idle",
          {exp_valid, tbl_we, tbl_addr}, 0);
    @(posedge clk); #1; rst = 1'b0;
    @(negedge clk);
    check(tbl_rd && tbl_addr == 0 && !exp_valid && !tbl_we, "R1 first read at address 0",
          {tbl_rd, tbl_addr}, {1'b1, 4'h0});
  endtask

  task automatic t_empty();
    int h0, w0, r0;
    h0 = 0; for (int i = 0; i < DEPTH; i++) h0 += hs_cnt[i];
    w0 = we_cnt; r0 = rd_cnt;
    repeat (80) @(posedge clk);
    @(negedge clk);
    begin
      int h1;
      h1 = 0; for (int i = 0; i < DEPTH; i++) h1 += hs_cnt[i];
      check(h1 == h0, "R3 free entries give no export", h1 - h0, 0);
    end
    check(we_cnt == w0, "R3 free entries give no write", we_cnt - w0, 0);
    check(rd_cnt - r0 >= 32, "R2 two full sweeps of reads", rd_cnt - r0, 32);
    check(order_err == 0, "R2 ascending wrapping order", order_err, 0);
  endtask

  task automatic t_idle();
    wipe(); set_time(1000, 50, 60000);
    put(4'd2, mkrec(1'b1, 4'd2, 16'd990, 16'd950));
    put(4'd7, mkrec(1'b1, 4'd7, 16'd990, 16'd951));
    pair_case("R4 idle limit", 4'd2, 4'd7);
  endtask

  task automatic t_life();
    wipe(); set_time(1000, 60000, 200);
    put(4'd3, mkrec(1'b1, 4'd3, 16'd800, 16'd999));
    put(4'd9, mkrec(1'b1, 4'd9, 16'd801, 16'd999));
    pair_case("R5 lifetime limit", 4'd3, 4'd9);
  endtask

  task automatic t_both();
    wipe(); set_time(1000, 50, 200);
    put(4'd4, mkrec(1'b1, 4'd4, 16'd700, 16'd900));
    put(4'd10, mkrec(1'b1, 4'd10, 16'd990, 16'd999));
    pair_case("R6 R11 both limits", 4'd4, 4'd10);
  endtask

  task automatic t_wrap();
    wipe(); set_time(20, 30, 1000);
    put(4'd5, mkrec(1'b1, 4'd5, 16'd65530, 16'd65526));
    put(4'd11, mkrec(1'b1, 4'd11, 16'd65530, 16'd65527));
    pair_case("R10 rollover", 4'd5, 4'd11);
  endtask

  task automatic t_stall();
    logic [REC_W-1:0] rec0;
    logic [AW-1:0] a0;
    int w0, r0, base, bad;
    wipe(); set_time(1000, 50, 60000);
    @(posedge clk); #1; exp_ready = 1'b0;
    put(4'd6, mkrec(1'b1, 4'd6, 16'd990, 16'd900));
    base = hs_cnt[6];
    for (int i = 0; i < 100 && !exp_valid; i++) @(negedge clk);
    check(exp_valid == 1'b1, "R9 export raised under stall", exp_valid, 1);
    check(exp_rec == golden[6], "R7 exported record as stored", exp_rec, golden[6]);
    rec0 = exp_rec; a0 = tbl_addr; w0 = we_cnt; r0 = rd_cnt; bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!exp_valid || exp_rec != rec0 || tbl_addr != a0) bad++;
    end
    check(bad == 0, "R9 record and address held", bad, 0);
    check(we_cnt == w0 && rd_cnt == r0, "R9 no access while stalled", we_cnt - w0 + rd_cnt - r0, 0);
    check(mem[6][REC_W-1] == 1'b1, "R8 entry busy until accepted", mem[6][REC_W-1], 1);
    @(posedge clk); #1; exp_ready = 1'b1;
    repeat (6) @(posedge clk);
    @(negedge clk);
    check(hs_cnt[6] - base == 1, "R11 accepted exactly once", hs_cnt[6] - base, 1);
    check(mem[6] == {1'b0, golden[6][REC_W-2:0]}, "R8 cleared after accept", mem[6],
          {1'b0, golden[6][REC_W-2:0]});
  endtask

  initial begin
    t_reset();
    t_empty();
    t_idle();
    t_life();
    t_both();
    t_wrap();
    t_stall();
    check(rec_err == 0, "R7 every export matches stored record", rec_err, 0);
    check(order_err == 0, "R2 order kept across run", order_err, 0);
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule